// File: doc/BRIEF.md
# Circular Bus Transfer Trace Buffer

This block watches a pipelined on-chip bus and writes one record into a ring of on-chip storage for each transfer that completes. The bus has separate address and data phases. The attributes of a transfer arrive in its address phase: address, direction, size, burst type and the index of the issuing master. The block holds them until the matching data phase completes, including any wait states. It then merges them with the data, the response code and a free-running cycle timestamp into one 16-byte record.

The number of records follows from a size parameter given in kilobytes. When the ring is full, the newest record replaces the oldest one. A small control port turns capture on and off, freezes capture without disturbing the stored records, and clears the write pointer. A registered read port returns any 32-bit word of any record. The current write pointer and a flag that shows the ring has wrapped are visible at all times, so software can locate the oldest record.

Top module: `tracebuf_top`

## Requirements
- R1: After reset the write pointer is 0, the wrapped flag is 0 and capture is off, so a completed transfer stores nothing.
- R2: With capture on, each completed transfer is stored at the write pointer. Word 0 holds the address. Word 1 holds the write data for a write or the read data for a read.
- R3: Word 2 of a record is the control word: bit 0 write flag, bits 3:1 size, bits 6:4 burst, bits 10:7 master index (4 bits by default), bits 12:11 response, and zero above.
- R4: Word 3 of a record holds the number of clock edges counted since reset was released, taken in the cycle in which the data phase completes.
- R5: Address-phase attributes are held from the cycle the address is accepted until the data phase completes. Bus wait states (ready low) delay the write, and a new address phase that overlaps the current data phase does not disturb the record being written.
- R6: The write pointer advances by one for each record and returns to 0 after the last slot. The wrapped flag then sets and stays set until a clear. Further records overwrite the oldest ones.
- R7: A control write with the enable bit (bit 0) at 0 turns capture off. The pointer and the stored records then stay unchanged across completed transfers.
- R8: A control write with the freeze bit (bit 1) at 1 stops capture while keeping all stored records. Writing it back to 0 resumes capture.
- R9: A control write with the clear bit (bit 2) at 1 sets the pointer to 0 and drops the wrapped flag without changing stored records. A clear wins over a capture in the same cycle, and that capture is lost.
- R10: A read request presents the selected word of the selected record one cycle later. The output then holds until the next request.
- R11: The ring holds SIZE_KB*64 records (128 at the default of 2 KB).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddrValid | input | 1 | Address phase of a transfer is present |
| busReady | input | 1 | Bus ready: completes a data phase and accepts an address phase |
| busAddr | input | 32 | Transfer address (address phase) |
| busWrite | input | 1 | Transfer is a write (address phase) |
| busSize | input | 3 | Transfer size code (address phase) |
| busBurst | input | 3 | Burst type code (address phase) |
| busMaster | input | MASTER_W | Index of the issuing master (address phase) |
| busWData | input | 32 | Write data (data phase) |
| busRData | input | 32 | Read data (data phase) |
| busResp | input | 2 | Response code (data phase) |
| ctrlWe | input | 1 | Control register write strobe |
| ctrlWData | input | 3 | Control value: bit 0 enable, bit 1 freeze, bit 2 clear |
| rdEn | input | 1 | Read request |
| rdIdx | input | IDX_W | Record index to read |
| rdWord | input | 2 | Word within the record (0 addr, 1 data, 2 control, 3 timestamp) |
| rdData | output | 32 | Registered read data |
| curPtr | output | IDX_W | Slot the next record will be written to |
| wrapped | output | 1 | Ring has wrapped at least once since reset or clear |

## Verification
A wrong pointer or wrapped state shows on curPtr or wrapped at the first clock edge after the transfer that caused it. It also sends a later record to the wrong slot, which a read-back then exposes. A fault in the address-phase hold register shows up only in the read-back of that record, as a wrong address or control word. The bench therefore corrupts the address-phase inputs during wait states and overlapping transfers, which makes such faults visible on the very next read. An off-by-one in the timestamp counter or a lost clear priority shows in word 3 or in curPtr one edge after the cycle concerned.

// File: rtl/tracebuf_pkg.sv
package tracebuf_pkg;
  localparam int WORD_W      = 32;
  localparam int ENTRY_BYTES = 16;
  localparam int ENTRY_W     = ENTRY_BYTES * 8;

  // control register bit positions
  localparam int CTRL_EN     = 0;
  localparam int CTRL_FREEZE = 1;
  localparam int CTRL_CLEAR  = 2;
  localparam int CTRL_W      = 3;

  typedef struct packed {
    logic latchAddr;  // address phase accepted: load hold register
    logic capture;    // data phase completed and capture allowed
    logic clear;      // reset pointer and wrapped flag
  } ctrlStrobes_t;
endpackage

// File: rtl/tracebuf_ctrl.sv
module tracebuf_ctrl
  import tracebuf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWe,
  input  logic [CTRL_W-1:0] ctrlWData,
  input  logic              busAddrValid,
  input  logic              busReady,
  output ctrlStrobes_t      strobes
);
  logic enableReg;
  logic freezeReg;
  logic pending;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableReg <= 1'b0;
      freezeReg <= 1'b0;
    end else if (ctrlWe) begin
      enableReg <= ctrlWData[CTRL_EN];
      freezeReg <= ctrlWData[CTRL_FREEZE];
    end
  end

  // a data phase is outstanding once an address phase is accepted
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= 1'b0;
    end else if (busReady) begin
      pending <= busAddrValid;
    end
  end

  always_comb begin
    strobes.latchAddr = busAddrValid && busReady;
    strobes.capture   = pending && busReady && enableReg && !freezeReg;
    strobes.clear     = ctrlWe && ctrlWData[CTRL_CLEAR];
  end
endmodule

// File: rtl/tracebuf_datapath.sv
module tracebuf_datapath
  import tracebuf_pkg::*;
#(
  parameter int DEPTH    = 128,
  parameter int MASTER_W = 4,
  localparam int IDX_W   = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strobes,
  input  logic [WORD_W-1:0]   busAddr,
  input  logic                busWrite,
  input  logic [2:0]          busSize,
  input  logic [2:0]          busBurst,
  input  logic [MASTER_W-1:0] busMaster,
  input  logic [WORD_W-1:0]   busWData,
  input  logic [WORD_W-1:0]   busRData,
  input  logic [1:0]          busResp,
  input  logic                rdEn,
  input  logic [IDX_W-1:0]    rdIdx,
  input  logic [1:0]          rdWord,
  output logic [WORD_W-1:0]   rdData,
  output logic [IDX_W-1:0]    curPtr,
  output logic                wrapped
);
  localparam int CTRL_USED = 9 + MASTER_W;
  localparam int CTRL_PAD  = WORD_W - CTRL_USED;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  // address-phase hold register
  logic [WORD_W-1:0]   holdAddr;
  logic                holdWrite;
  logic [2:0]          holdSize;
  logic [2:0]          holdBurst;
  logic [MASTER_W-1:0] holdMaster;

  logic [WORD_W-1:0]   tsCnt;
  logic [ENTRY_W-1:0]  ring [DEPTH];
  logic [WORD_W-1:0]   ctrlWord;
  logic [WORD_W-1:0]   dataWord;
  logic [ENTRY_W-1:0]  newEntry;
  logic [6:0]          rdBase;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdAddr   <= '0;
      holdWrite  <= 1'b0;
      holdSize   <= '0;
      holdBurst  <= '0;
      holdMaster <= '0;
    end else if (strobes.latchAddr) begin
      holdAddr   <= busAddr;
      holdWrite  <= busWrite;
      holdSize   <= busSize;
      holdBurst  <= busBurst;
      holdMaster <= busMaster;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) tsCnt <= '0;
    else       tsCnt <= tsCnt + 1'b1;
  end

  always_comb begin
    ctrlWord = {{CTRL_PAD{1'b0}}, busResp, holdMaster, holdBurst, holdSize, holdWrite};
    dataWord = holdWrite ? busWData : busRData;
    newEntry = {tsCnt, ctrlWord, dataWord, holdAddr};
  end

  // storage is not reset: contents survive clear and freeze
  always_ff @(posedge clk) begin
    if (strobes.capture && !strobes.clear) ring[curPtr] <= newEntry;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobes.clear) begin
      curPtr  <= '0;
      wrapped <= 1'b0;
    end else if (strobes.capture) begin
      if (curPtr == LAST_IDX) begin
        curPtr  <= '0;
        wrapped <= 1'b1;
      end else begin
        curPtr <= curPtr + 1'b1;
      end
    end
  end

  assign rdBase = {rdWord, 5'b00000};

  always_ff @(posedge clk) begin
    if (!rstN)     rdData <= '0;
    else if (rdEn) rdData <= ring[rdIdx][rdBase +: WORD_W];
  end
endmodule

// File: rtl/tracebuf_top.sv
module tracebuf_top
  import tracebuf_pkg::*;
#(
  parameter int SIZE_KB  = 2,
  parameter int MASTER_W = 4,
  localparam int DEPTH   = SIZE_KB * 1024 / ENTRY_BYTES,
  localparam int IDX_W   = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busAddrValid,
  input  logic                busReady,
  input  logic [31:0]         busAddr,
  input  logic                busWrite,
  input  logic [2:0]          busSize,
  input  logic [2:0]          busBurst,
  input  logic [MASTER_W-1:0] busMaster,
  input  logic [31:0]         busWData,
  input  logic [31:0]         busRData,
  input  logic [1:0]          busResp,
  input  logic                ctrlWe,
  input  logic [2:0]          ctrlWData,
  input  logic                rdEn,
  input  logic [IDX_W-1:0]    rdIdx,
  input  logic [1:0]          rdWord,
  output logic [31:0]         rdData,
  output logic [IDX_W-1:0]    curPtr,
  output logic                wrapped
);
  ctrlStrobes_t strobes;
  logic captureStb;
  logic clearStb;

  assign captureStb = strobes.capture;
  assign clearStb   = strobes.clear;

  tracebuf_ctrl ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .ctrlWe       (ctrlWe),
    .ctrlWData    (ctrlWData),
    .busAddrValid (busAddrValid),
    .busReady     (busReady),
    .strobes      (strobes)
  );

  tracebuf_datapath #(
    .DEPTH    (DEPTH),
    .MASTER_W (MASTER_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .busAddr   (busAddr),
    .busWrite  (busWrite),
    .busSize   (busSize),
    .busBurst  (busBurst),
    .busMaster (busMaster),
    .busWData  (busWData),
    .busRData  (busRData),
    .busResp   (busResp),
    .rdEn      (rdEn),
    .rdIdx     (rdIdx),
    .rdWord    (rdWord),
    .rdData    (rdData),
    .curPtr    (curPtr),
    .wrapped   (wrapped)
  );
endmodule

// File: rtl/tracebuf_checker.sv
module tracebuf_checker #(
  parameter int DEPTH   = 128,
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rstN,
  input logic             captureStb,
  input logic             clearStb,
  input logic             ctrlWe,
  input logic [2:0]       ctrlWData,
  input logic [IDX_W-1:0] curPtr,
  input logic             wrapped
);
  // R6: each record moves the pointer one slot, modulo the depth
  p_ptr_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    captureStb && !clearStb |=> curPtr == IDX_W'($past(curPtr) + 1'b1));

  // R6: wrap from the last slot sets the flag
  p_wrap_set_r6: assert property (@(posedge clk) disable iff (!rstN)
    captureStb && !clearStb && curPtr == IDX_W'(DEPTH - 1) |=> wrapped && curPtr == '0);

  // R6: the flag is sticky until a clear
  p_wrap_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    wrapped && !clearStb |=> wrapped);

  // R7: without a capture or clear the pointer holds
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !captureStb && !clearStb |=> $stable(curPtr));

  // R8: once frozen, the pointer does not move
  p_freeze_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWe && ctrlWData[1] && !ctrlWData[2]) ##1 !ctrlWe |=> $stable(curPtr));

  // R9: clear returns pointer and flag to zero
  p_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    clearStb |=> curPtr == '0 && !wrapped);
endmodule

bind tracebuf_top tracebuf_checker #(.DEPTH(DEPTH)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .captureStb (captureStb),
  .clearStb   (clearStb),
  .ctrlWe     (ctrlWe),
  .ctrlWData  (ctrlWData),
  .curPtr     (curPtr),
  .wrapped    (wrapped)
);

// File: tb/tracebuf_tb_top.sv
`timescale 1ns/1ps
module tracebuf_top_tb_top;
  localparam int DEPTH = 128;
  localparam int IDX_W = 7;

  typedef struct packed {
    logic [31:0] addr;
    logic        wr;
    logic [2:0]  size;
    logic [2:0]  burst;
    logic [3:0]  master;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic [1:0]  resp;
    logic [3:0]  waits;
  } vec_t;

  localparam int NVEC = 4;
  localparam vec_t VECS [NVEC] = '{
    '{32'h1000_0040, 1'b1, 3'd2, 3'd0, 4'd1, 32'hDEAD_BEEF, 32'h0000_0000, 2'd0, 4'd0},
    '{32'h8000_0104, 1'b0, 3'd1, 3'd3, 4'd7, 32'h0000_0000, 32'hCAFE_F00D, 2'd1, 4'd2},
    '{32'hFFFF_FFFC, 1'b1, 3'd0, 3'd7, 4'd15, 32'h1234_5678, 32'h0BAD_0BAD, 2'd3, 4'd5},
    '{32'h0000_0000, 1'b0, 3'd7, 3'd5, 4'd0, 32'h5555_AAAA, 32'h8765_4321, 2'd2, 4'd1}
  };

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             busAddrValid = 1'b0;
  logic             busReady = 1'b1;
  logic [31:0]      busAddr = '0;
  logic             busWrite = 1'b0;
  logic [2:0]       busSize = '0;
  logic [2:0]       busBurst = '0;
  logic [3:0]       busMaster = '0;
  logic [31:0]      busWData = '0;
  logic [31:0]      busRData = '0;
  logic [1:0]       busResp = '0;
  logic             ctrlWe = 1'b0;
  logic [2:0]       ctrlWData = '0;
  logic             rdEn = 1'b0;
  logic [IDX_W-1:0] rdIdx = '0;
  logic [1:0]       rdWord = '0;
  logic [31:0]      rdData;
  logic [IDX_W-1:0] curPtr;
  logic             wrapped;

  int checks = 0;
  int fails = 0;
  logic [31:0] cyc;
  logic [31:0] tsList [8];

  always #2.5 clk = ~clk;

  // edges since reset release, per R4
  always_ff @(posedge clk) begin
    if (!rstN) cyc <= '0;
    else       cyc <= cyc + 1'b1;
  end

  tracebuf_top dut_i (
    .clk(clk), .rstN(rstN), .busAddrValid(busAddrValid), .busReady(busReady),
    .busAddr(busAddr), .busWrite(busWrite), .busSize(busSize), .busBurst(busBurst),
    .busMaster(busMaster), .busWData(busWData), .busRData(busRData), .busResp(busResp),
    .ctrlWe(ctrlWe), .ctrlWData(ctrlWData), .rdEn(rdEn), .rdIdx(rdIdx), .rdWord(rdWord),
    .rdData(rdData), .curPtr(curPtr), .wrapped(wrapped)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expCtrl(input vec_t v);
    return {19'b0, v.resp, v.master, v.burst, v.size, v.wr};
  endfunction

  task automatic ctrlWrite(input logic [2:0] val);
    @(negedge clk);
    ctrlWe = 1'b1; ctrlWData = val;
    @(negedge clk);
    ctrlWe = 1'b0; ctrlWData = '0;
  endtask

  task automatic driveAddr(input vec_t v);
    busAddrValid = 1'b1; busAddr = v.addr; busWrite = v.wr;
    busSize = v.size; busBurst = v.burst; busMaster = v.master;
  endtask

  task automatic junkAddr();
    busAddrValid = 1'b0; busAddr = 32'h5A5A_5A5A; busWrite = 1'b0;
    busSize = 3'd6; busBurst = 3'd6; busMaster = 4'd9;
  endtask

  task automatic driveData(input vec_t v);
    busWData = v.wdata; busRData = v.rdata; busResp = v.resp;
  endtask

  task automatic doXfer(input vec_t v, output logic [31:0] ts);
    @(negedge clk);
    driveAddr(v); busReady = 1'b1;
    @(negedge clk);
    junkAddr(); driveData(v);
    busReady = 1'b0;
    repeat (int'(v.waits)) @(negedge clk);
    busReady = 1'b1;
    ts = cyc;
    @(negedge clk);
    busWData = '0; busRData = '0; busResp = '0;
  endtask

  task automatic readWord(input int idx, input int w, output logic [31:0] val);
    @(negedge clk);
    rdEn = 1'b1; rdIdx = IDX_W'(idx); rdWord = 2'(w);
    @(negedge clk);
    rdEn = 1'b0;
    val = rdData;
  endtask

  task automatic checkEntry(input string tag, input int idx, input vec_t v, input logic [31:0] ts);
    logic [31:0] val;
    readWord(idx, 0, val); chk({tag, " R2 addr"}, val, v.addr);
    readWord(idx, 1, val); chk({tag, " R2 data"}, val, v.wr ? v.wdata : v.rdata);
    readWord(idx, 2, val); chk({tag, " R3 ctrl"}, val, expCtrl(v));
    readWord(idx, 3, val); chk({tag, " R4 ts"}, val, ts);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] ts;
    logic [31:0] val;
    vec_t q;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 ptr after reset", 32'(curPtr), 0);
    chk("R1 wrapped after reset", 32'(wrapped), 0);

    doXfer(VECS[0], ts);
    chk("R1 capture off after reset", 32'(curPtr), 0);

    ctrlWrite(3'b001);
    for (int i = 0; i < NVEC; i++) begin
      doXfer(VECS[i], ts);
      tsList[i] = ts;
      chk("R6 ptr advance", 32'(curPtr), 32'(i + 1));
      checkEntry("vec R5", i, VECS[i], ts);
    end

    // R5 overlapping address and data phases
    @(negedge clk);
    driveAddr(VECS[2]); busReady = 1'b1;
    @(negedge clk);
    driveAddr(VECS[3]); driveData(VECS[2]); tsList[4] = cyc;
    @(negedge clk);
    junkAddr(); driveData(VECS[3]); tsList[5] = cyc;
    @(negedge clk);
    chk("R5 overlap ptr", 32'(curPtr), 6);
    checkEntry("R5 overlap A", 4, VECS[2], tsList[4]);
    checkEntry("R5 overlap B", 5, VECS[3], tsList[5]);

    // R8 freeze
    ctrlWrite(3'b011);
    doXfer(VECS[1], ts);
    chk("R8 frozen ptr", 32'(curPtr), 6);
    readWord(5, 0, val); chk("R8 contents kept", val, VECS[3].addr);
    ctrlWrite(3'b001);
    doXfer(VECS[0], ts);
    chk("R8 resume ptr", 32'(curPtr), 7);
    checkEntry("R8 resume", 6, VECS[0], ts);

    // R7 disable
    ctrlWrite(3'b000);
    doXfer(VECS[1], ts);
    chk("R7 disabled ptr", 32'(curPtr), 7);
    readWord(6, 0, val); chk("R7 entry untouched", val, VECS[0].addr);

    // R10 read output holds without a request
    readWord(1, 0, val);
    @(negedge clk); rdIdx = 7'd3; rdWord = 2'd1;
    @(negedge clk);
    chk("R10 rdData holds", rdData, VECS[1].addr);

    // R9 clear
    ctrlWrite(3'b101);
    chk("R9 clear ptr", 32'(curPtr), 0);
    chk("R9 clear wrapped", 32'(wrapped), 0);
    readWord(0, 0, val); chk("R9 contents kept", val, VECS[0].addr);

    // R9 clear wins over a capture in the same cycle
    @(negedge clk);
    driveAddr(VECS[2]); busReady = 1'b1;
    @(negedge clk);
    junkAddr(); driveData(VECS[2]);
    ctrlWe = 1'b1; ctrlWData = 3'b101;
    @(negedge clk);
    ctrlWe = 1'b0; ctrlWData = '0;
    chk("R9 clear priority ptr", 32'(curPtr), 0);
    readWord(0, 0, val); chk("R9 capture dropped", val, VECS[0].addr);

    // R6 / R11 fill and wrap
    q = VECS[0];
    for (int i = 0; i < DEPTH - 1; i++) begin
      q.addr = 32'(i) | 32'hA000_0000;
      doXfer(q, ts);
    end
    chk("R11 ptr at last slot", 32'(curPtr), DEPTH - 1);
    chk("R11 not wrapped before full", 32'(wrapped), 0);
    q.addr = 32'hBEEF_0001;
    doXfer(q, ts);
    chk("R6 wrap ptr", 32'(curPtr), 0);
    chk("R6 wrapped set", 32'(wrapped), 1);
    readWord(DEPTH - 1, 0, val); chk("R11 last slot", val, 32'hBEEF_0001);
    q.addr = 32'hBEEF_0002;
    doXfer(q, ts);
    readWord(0, 0, val); chk("R6 oldest overwritten", val, 32'hBEEF_0002);
    checkEntry("R6 overwrite", 0, q, ts);
    chk("R6 wrapped sticky", 32'(wrapped), 1);
    chk("R6 ptr after overwrite", 32'(curPtr), 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule